// File: doc/BRIEF.md
# Erasable PROM Mode-Decode Model

This block is a synthesizable functional model of a byte-wide, UV-erasable programmable read-only memory. The array depth is a parameter. Every clock it decodes five control levels into one operating mode: read, output disable, standby, program, program verify, program inhibit or signature read. The levels are the active-low chip select, the active-low output enable, the active-low program strobe, and two logic flags. One flag stands for the raised programming supply. The other stands for the high voltage placed on address pin 9. Voltages, currents and analog timing are not modelled. Access time is a fixed number of clock cycles.

Programming merges the input byte into the addressed word with a bitwise AND, so a bit can only fall from 1 to 0. Only the erase input can return bits to 1, and it does so for the whole array in one edge. The signature mode replaces the array with a fixed two-byte identifier. The data output is tri-state in style: `dout_en` says the model would drive its pins, and `dout_valid` says the byte on `dout` has completed its access time. The read path has no back-pressure, because a memory output cannot stall. A consumer samples `dout` on any cycle in which `dout_valid` is high. The byte then holds for as long as the mode and the address stay the same.

Top module: `eprom_model`

## Requirements
- R1: Read mode is chip select low, output enable low, supply flag low and pin-9 flag low. In this mode `dout` carries the stored byte at `addr`.
- R2: Output disable (chip select low, output enable high, supply flag low) and standby (chip select high) hold `dout_en` and `dout_valid` low and `dout` at 0 after the next rising edge.
- R3: Program mode is chip select low, output enable high, program strobe low and supply flag high. Each rising edge in this mode replaces the word at `addr` with its old value AND `din`, so no stored bit ever rises.
- R4: Program verify is chip select low, output enable low, program strobe high and supply flag high. It drives the stored byte at `addr`. The pin-9 flag is ignored in this mode.
- R5: While chip select or the program strobe is high, no array word changes. With chip select low, output enable high, strobe high and supply flag high, the outputs stay quiet.
- R6: Signature mode is chip select low, output enable low, pin-9 flag high and supply flag low. With `addr[0]`=0 it returns 0x97, and with `addr[0]`=1 it returns 0xD6. `addr[9]` is ignored.
- R7: An edge with `erase` high sets every bit of every word to 1. Erase takes priority over a program write on the same edge.
- R8: In signature mode, if any address bit other than bit 0 and bit 9 is high, the model returns 0xFF and `sig_err` is high. Otherwise `sig_err` is low.
- R9: The access key is the decoded mode together with `addr`. `dout_valid` goes low on the first edge that samples a new key. It rises on the LATENCY-th consecutive edge that samples the same key in a driving mode (read, verify or signature).
- R10: `dout_en` follows the decoded mode after one rising edge, without the access latency.
- R11: Chip select low, output enable low, program strobe low and supply flag high is an invalid combination. It drives nothing and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the control and output registers (the array is kept) |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | High voltage present on address pin 9 |
| erase | input | 1 | Erase the whole array to all ones |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Program data |
| dout | output | DATA_W | Output byte, 0 while not valid |
| dout_en | output | 1 | Model would drive its data pins |
| dout_valid | output | 1 | Output byte has met the access latency |
| sig_err | output | 1 | Signature read with stray address bits high |

## Verification
The assertions check on every cycle that:
- no stored bit rises except through erase;
- an erase edge leaves the addressed word all ones;
- no write happens while chip select or the strobe is high;
- a new access key drops `dout_valid`;
- standby empties the output on the next cycle;
- at most one driving or writing mode is decoded at a time.

The bench scenarios show the values themselves:
- the bytes left by several successive programs of one word;
- the two identifier bytes and the 0xFF error return;
- erase winning over a program on the same edge;
- the exact edge on which `dout_valid` rises.

A reference array in the bench, fed with random program and read traffic, checks data integrity across many addresses.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [2:0] {
    M_STANDBY = 3'd0,
    M_OUTDIS  = 3'd1,
    M_READ    = 3'd2,
    M_PROG    = 3'd3,
    M_VERIFY  = 3'd4,
    M_INHIBIT = 3'd5,
    M_SIG     = 3'd6
  } mode_e;

  localparam int MODE_W = 3;
  localparam logic [7:0] ID_MAKER = 8'h97;
  localparam logic [7:0] ID_PART  = 8'hD6;

  function automatic logic mode_drives(mode_e m);
    return (m == M_READ) || (m == M_VERIFY) || (m == M_SIG);
  endfunction

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
  import eprom_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  pgm_n,
  input  logic  vpp_hi,
  input  logic  id_hv,
  output mode_e mode,
  output logic  prog_en,
  output logic  drive
);

  always_comb begin
    if (ce_n) begin
      mode = M_STANDBY;
    end else if (!oe_n) begin
      if (vpp_hi) begin
        mode = pgm_n ? M_VERIFY : M_OUTDIS;
      end else if (id_hv) begin
        mode = M_SIG;
      end else begin
        mode = M_READ;
      end
    end else begin
      if (vpp_hi) begin
        mode = pgm_n ? M_INHIBIT : M_PROG;
      end else begin
        mode = M_OUTDIS;
      end
    end
  end

  assign prog_en = (mode == M_PROG);
  assign drive   = mode_drives(mode);

  // R5 / R11: a write never coexists with a raised select or strobe, or with an active output enable
  always_comb begin
    p_inhibit_r5: assert (!(prog_en && (ce_n || pgm_n || !oe_n)));
    p_drive_excl_r11: assert ($onehot0({prog_en, drive}));
  end

endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              prog_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= '1;
      end
    end else if (prog_en) begin
      mem[addr] <= mem[addr] & din;
    end
  end

  assign rd_data = mem[addr];

  // R3: outside erase, no bit of the addressed word may rise
  p_clear_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(erase) && $stable(addr)) |-> ((rd_data & ~$past(rd_data)) == '0));

  // R7: after an erase edge, whichever word is addressed reads all ones
  p_erase_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(erase) |-> (rd_data == '1));

  // R5: with no write and no erase the addressed word holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(prog_en) && !$past(erase) && $stable(addr)) |-> $stable(rd_data));

endmodule

// File: rtl/eprom_sig_rom.sv
module eprom_sig_rom
  import eprom_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 8,
  parameter int HV_PIN  = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] id_data,
  output logic              id_bad
);

  localparam logic [ADDR_W-1:0] CARE_MASK =
    ~((ADDR_W'(1) << HV_PIN) | ADDR_W'(1));

  assign id_bad = |(addr & CARE_MASK);

  always_comb begin
    if (id_bad) begin
      id_data = '1;
    end else if (addr[0]) begin
      id_data = DATA_W'(ID_PART);
    end else begin
      id_data = DATA_W'(ID_MAKER);
    end
  end

  // R8: a stray address bit always yields the all-ones return
  always_comb begin
    p_bad_ones_r8: assert (!id_bad || (id_data == '1));
  end

endmodule

// File: rtl/eprom_access_timer.sv
module eprom_access_timer #(
  parameter int KEY_W   = 13,
  parameter int LATENCY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] key,
  input  logic             drive,
  output logic             drive_q,
  output logic             valid
);

  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LATENCY);

  logic [KEY_W-1:0] key_q;
  logic [CNT_W-1:0] cnt;
  logic             key_new;

  assign key_new = (key != key_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q   <= '0;
      cnt     <= '0;
      drive_q <= 1'b0;
    end else begin
      key_q   <= key;
      drive_q <= drive;
      if (key_new) begin
        cnt <= CNT_W'(1);
      end else if (cnt != CNT_TOP) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign valid = drive_q && (cnt == CNT_TOP);

  // R9: a fresh key drops the valid flag on the next cycle when latency exceeds one
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((LATENCY > 1) && key_new) |=> !valid);

  // R9: valid never rises without the key having been held
  p_rise_needs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> ($stable(key_q) || (LATENCY == 1)));

endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 8,
  parameter int LATENCY = 3,
  parameter int HV_PIN  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              dout_valid,
  output logic              sig_err
);

  localparam int KEY_W = MODE_W + ADDR_W;

  mode_e             mode;
  logic              prog_en;
  logic              drive;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] id_data;
  logic              id_bad;
  logic [DATA_W-1:0] sel_data;
  logic [DATA_W-1:0] data_q;
  logic              sig_err_q;
  logic              valid;

  eprom_mode_decode u_dec (
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .pgm_n   (pgm_n),
    .vpp_hi  (vpp_hi),
    .id_hv   (id_hv),
    .mode    (mode),
    .prog_en (prog_en),
    .drive   (drive)
  );

  eprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .erase   (erase),
    .prog_en (prog_en),
    .addr    (addr),
    .din     (din),
    .rd_data (rd_data)
  );

  eprom_sig_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HV_PIN(HV_PIN)) u_sig (
    .addr    (addr),
    .id_data (id_data),
    .id_bad  (id_bad)
  );

  eprom_access_timer #(.KEY_W(KEY_W), .LATENCY(LATENCY)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .key     ({mode, addr}),
    .drive   (drive),
    .drive_q (dout_en),
    .valid   (valid)
  );

  assign sel_data = (mode == M_SIG) ? id_data : rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      sig_err_q <= 1'b0;
    end else begin
      data_q    <= sel_data;
      sig_err_q <= (mode == M_SIG) && id_bad;
    end
  end

  assign dout       = valid ? data_q : '0;
  assign dout_valid = valid;
  assign sig_err    = sig_err_q;

  // R2: a standby cycle leaves the outputs quiet on the next cycle
  p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n) |-> (!dout_en && !dout_valid && (dout == '0)));

  // R8: the error flag only appears with a driving output
  p_err_driven_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sig_err |-> dout_en);

  // R10: the enable follows a driving mode after one edge
  p_enable_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp_hi) |=> dout_en);

endmodule

// File: tb/eprom_model_test.sv
module eprom_model_test;

  localparam int AW  = 10;
  localparam int DW  = 8;
  localparam int LAT = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n, ce_n, oe_n, pgm_n, vpp_hi, id_hv, erase;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_en, dout_valid, sig_err;

  logic [DW-1:0] gold_mem [DEPTH];
  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  eprom_model #(.ADDR_W(AW), .DATA_W(DW), .LATENCY(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .id_hv(id_hv), .erase(erase), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .dout_valid(dout_valid), .sig_err(sig_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input logic c, input logic o, input logic p, input logic v,
                      input logic h, input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; id_hv = h; addr = a; din = d;
  endtask

  function automatic logic [DW-1:0] sig_exp(input logic [AW-1:0] a);
    if ((a & ~(AW'(1) << 9) & ~AW'(1)) != '0) return 8'hFF;
    return a[0] ? 8'hD6 : 8'h97;
  endfunction

  task automatic do_erase();
    erase = 1'b1;
    tick(1);
    erase = 1'b0;
    for (int i = 0; i < DEPTH; i++) gold_mem[i] = '1;
  endtask

  task automatic do_prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
    pins(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, a, d);
    tick(1);
    gold_mem[a] = gold_mem[a] & d;
    pins(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, a, '0);
    tick(1);
  endtask

  // read (verify=0) or verify (verify=1); checks valid low just before the latency expires
  task automatic do_read(input string req, input logic [AW-1:0] a, input logic verify);
    pins(1'b0, 1'b0, 1'b1, verify, 1'b0, a, '0);
    tick(LAT - 1);
    check({req, " R9 early"}, {31'd0, dout_valid}, 32'd0);
    tick(1);
    check({req, " R9 valid"}, {31'd0, dout_valid}, 32'd1);
    check(req, {24'd0, dout}, {24'd0, gold_mem[a]});
  endtask

  task automatic do_sig(input logic [AW-1:0] a);
    pins(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, a, '0);
    tick(LAT);
    check("R6 signature byte", {24'd0, dout}, {24'd0, sig_exp(a)});
    check("R8 signature error", {31'd0, sig_err}, {31'd0, sig_exp(a) == 8'hFF});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; erase = 1'b0;
    pins(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
    tick(3);
    check("R2 reset dout_en", {31'd0, dout_en}, 32'd0);
    check("R2 reset valid", {31'd0, dout_valid}, 32'd0);
    check("R8 reset sig_err", {31'd0, sig_err}, 32'd0);
    rst_n = 1'b1;
    tick(1);

    do_erase();
    do_read("R7 R1 erased read", 10'd5, 1'b0);

    // R10: enable after one edge, valid still low
    pins(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd6, '0);
    tick(1);
    check("R10 enable early", {31'd0, dout_en}, 32'd1);
    check("R9 valid early", {31'd0, dout_valid}, 32'd0);

    do_prog(10'd5, 8'hA5);
    do_prog(10'd5, 8'h5F);
    do_read("R3 R4 verify after merge", 10'd5, 1'b1);
    check("R3 merged value", {24'd0, dout}, 32'h05);

    // R5 inhibit: strobe high with supply raised and zero data
    pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd5, 8'h00);
    tick(2);
    check("R5 inhibit quiet", {31'd0, dout_en}, 32'd0);
    // R5 standby with strobe low and supply raised
    pins(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 10'd5, 8'h00);
    tick(2);
    check("R2 standby quiet", {31'd0, dout_en}, 32'd0);
    do_read("R5 word unchanged", 10'd5, 1'b0);

    // R2 output disable
    pins(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd5, '0);
    tick(1);
    check("R2 outdis enable", {31'd0, dout_en}, 32'd0);
    check("R2 outdis data", {24'd0, dout}, 32'd0);

    // R11 invalid combination
    pins(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd5, 8'h00);
    tick(LAT + 1);
    check("R11 no drive", {31'd0, dout_en}, 32'd0);
    do_read("R11 no write", 10'd5, 1'b0);

    // R4 verify ignores the pin-9 flag
    pins(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'd5, '0);
    tick(LAT);
    check("R4 verify with hv", {24'd0, dout}, 32'h05);

    do_sig(10'h000);
    do_sig(10'h001);
    do_sig(10'h201);
    do_sig(10'h004);
    do_sig(10'h081);

    // R7: erase wins over a program on the same edge
    pins(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd7, 8'h00);
    do_erase();
    do_read("R7 erase priority", 10'd7, 1'b0);
    do_read("R7 whole array", 10'd5, 1'b0);

    for (int it = 0; it < 400; it++) begin
      logic [AW-1:0] a;
      int op;
      a  = AW'($urandom_range(0, 31));
      op = $urandom_range(0, 3);
      case (op)
        0: do_prog(a, DW'($urandom));
        1: do_read("R1 random read", a, 1'b0);
        2: do_read("R4 random verify", a, 1'b1);
        default: do_sig(($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 1)));
      endcase
    end

    finish_run();
  end

endmodule